// File: doc/BRIEF.md
# Open-Collector Output Port with Input Synchronizer

This block is a port of open-collector pins that tolerate high voltage, controlled from a small memory-mapped register bus. Each pin has two register bits. One is an output bit. When it is one, the pin's pull-down transistor turns on and the pin goes low. When it is zero, the pin floats and an external pull-up sets its level. The block never drives a pin high. The other is an input bit, which shows the pad level after it passes through a synchronizer.

The output bits and the input bits sit at two separate addresses. One write strobe and one read strobe serve every pin. A one-bit address chooses between the output register and the synchronized input levels. The reset is active high and asynchronous. It releases every pin at once, even when no clock is running.

The synchronizer has two stages: a latch that is transparent while the clock is low, followed by a flip-flop that captures on the rising edge. A sleep input forces the synchronizer input to zero, so a floating pad cannot toggle it while the device sleeps.

Top module: `hvport`

## Requirements
- R1: A write with address 0 stores the write data in the output register. `pulldn_en` equals the written value from the rising edge that takes the write.
- R2: A pin whose output bit is one has its pull-down on, and the pin is low. Once the synchronizer delay has passed, its input bit reads 0 whatever the external level is.
- R3: When `rst` is high, `pulldn_en`, the synchronizer flip-flops and `bus_rdata` go to zero at once, without waiting for a clock edge.
- R4: A pad change made after a rising edge is captured by the next rising edge. A read taken at that same edge still returns the old level, and a read at the edge after it returns the new level.
- R5: While `sleep_en` is 1, the synchronizer input is forced to 0. A read of address 1 after the synchronizer delay returns all zeros.
- R6: `bus_rdata` is registered and is updated on each rising edge. When `bus_rd` is 1 at that edge, address 0 returns the output register and address 1 returns the synchronized pad levels, each as it stood before that edge.
- R7: After a rising edge at which `bus_rd` is 0, `bus_rdata` is all zeros.
- R8: A write with address 1 is ignored. The output register and `pulldn_en` keep their value.
- R9: A read and a write of address 0 at the same edge return the register value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Asynchronous reset, active high |
| sleep_en | input | 1 | Forces the synchronizer input to zero while high |
| bus_wr | input | 1 | Write strobe, shared by all pins |
| bus_rd | input | 1 | Read strobe, shared by all pins |
| bus_addr | input | 1 | 0 selects the output register, 1 selects the input levels |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data, zero when there is no read |
| pad_lvl | input | W | Level seen at each pad |
| pulldn_en | output | W | Pull-down enable for each pin, equal to the output register |

## Verification
The bench builds the port with its default width of 8. The output and input bytes then carry mixed bit patterns, such as A5 and 3C, so bits with the pull-down on and bits left floating sit side by side. A single wrong bit lane or an inverted bit therefore shows up in the read-back value. The bench models each pad as an open-collector line with an external pull-up whose level it sets per bit. This exposes the one-edge delay on input levels and the forced-low reading of pulled-down pins. Directed tests then change a pad during the clock's low phase and raise reset in the middle of a cycle.

// File: rtl/hvport_pkg.sv
package hvport_pkg;
  typedef enum logic {
    SEL_OUT = 1'b0,
    SEL_IN  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/hvport_outreg.sv
module hvport_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  // Asynchronous clear so pins float even without a running clock
  always_ff @(posedge clk or posedge rst) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wdata;
  end
endmodule

// File: rtl/hvport_sync.sv
module hvport_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sleep_en,
  input  logic [W-1:0] pad,
  output logic [W-1:0] q
);
  logic [W-1:0] gated;
  logic [W-1:0] lat_q;

  assign gated = sleep_en ? '0 : pad;

  for (genvar b = 0; b < W; b++) begin : g_bit
    // First stage: transparent while clock low, holds while high
    always_latch begin
      if (!clk) lat_q[b] <= gated[b];
    end
    // Second stage: captured on the rising edge
    always_ff @(posedge clk or posedge rst) begin
      if (rst) q[b] <= 1'b0;
      else     q[b] <= lat_q[b];
    end
  end
endmodule

// File: rtl/hvport_rdmux.sv
module hvport_rdmux
  import hvport_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en,
  input  reg_sel_e     sel,
  input  logic [W-1:0] out_bits,
  input  logic [W-1:0] in_bits,
  output logic [W-1:0] rdata
);
  logic [W-1:0] pick;

  always_comb begin
    unique case (sel)
      SEL_OUT: pick = out_bits;
      SEL_IN:  pick = in_bits;
      default: pick = '0;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= pick;
    else            rdata <= '0;
  end
endmodule

// File: rtl/hvport.sv
module hvport
  import hvport_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sleep_en,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic         bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pad_lvl,
  output logic [W-1:0] pulldn_en
);
  reg_sel_e     sel;
  logic         out_wr;
  logic [W-1:0] out_q;
  logic [W-1:0] sync_q;

  assign sel    = reg_sel_e'(bus_addr);
  assign out_wr = bus_wr && (sel == SEL_OUT);

  hvport_outreg #(.W(W)) u_outreg (
    .clk   (clk),
    .rst   (rst),
    .wr_en (out_wr),
    .wdata (bus_wdata),
    .q     (out_q)
  );

  hvport_sync #(.W(W)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sleep_en (sleep_en),
    .pad      (pad_lvl),
    .q        (sync_q)
  );

  hvport_rdmux #(.W(W)) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (bus_rd),
    .sel      (sel),
    .out_bits (out_q),
    .in_bits  (sync_q),
    .rdata    (bus_rdata)
  );

  assign pulldn_en = out_q;
endmodule

// File: rtl/hvport_chk.sv
module hvport_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         sleep_en,
  input logic         bus_wr,
  input logic         bus_rd,
  input logic         bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] pad_lvl,
  input logic [W-1:0] pulldn_en
);
  assert_port_write_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_addr) |=> (pulldn_en == $past(bus_wdata)));

  assert_pulled_low_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr) |=> ((bus_rdata & $past(pulldn_en, 2)) == '0));

  assert_reset_floats_R3: assert property (@(negedge clk)
    rst |-> (pulldn_en == '0 && bus_rdata == '0));

  assert_sleep_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr && $past(sleep_en)) |=> (bus_rdata == '0));

  assert_port_readback_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_addr) |=> (bus_rdata == $past(pulldn_en)));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  assert_pin_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr) |=> $stable(pulldn_en));
endmodule

bind hvport hvport_chk #(.W(W)) u_chk (.*);

// File: tb/test_hvport.sv
module test_hvport;
  localparam int W = 8;
  localparam int NV = 15;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sleep_en = 1'b0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic         bus_addr = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pad_lvl;
  logic [W-1:0] pulldn_en;
  logic [W-1:0] ext_lvl = '1;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // open collector pad with external pull-up; ext_lvl models another driver
  assign pad_lvl = ext_lvl & ~pulldn_en;

  hvport #(.W(W)) i_hvport (.*);

  // {wr, rd, addr, wdata, ext, sleep, exp_rdata, exp_pulldn}
  localparam logic [35:0] VEC [0:NV-1] = '{
    {1'b1,1'b0,1'b0,8'hA5,8'hFF,1'b0,8'h00,8'hA5},  // R1 write
    {1'b0,1'b1,1'b0,8'h00,8'hFF,1'b0,8'hA5,8'hA5},  // R6 out read
    {1'b0,1'b1,1'b1,8'h00,8'hFF,1'b0,8'h5A,8'hA5},  // R2 R6 in read
    {1'b1,1'b0,1'b1,8'hFF,8'hFF,1'b0,8'h00,8'hA5},  // R8 write to in addr
    {1'b0,1'b1,1'b0,8'h00,8'hFF,1'b0,8'hA5,8'hA5},  // R8 readback
    {1'b1,1'b1,1'b0,8'h3C,8'hFF,1'b0,8'hA5,8'h3C},  // R9 read+write
    {1'b0,1'b1,1'b1,8'h00,8'hFF,1'b0,8'h5A,8'h3C},  // R4 old pattern
    {1'b0,1'b1,1'b1,8'h00,8'h0F,1'b0,8'hC3,8'h3C},  // R2 new pattern
    {1'b0,1'b1,1'b1,8'h00,8'h0F,1'b1,8'h03,8'h3C},  // R5 sleep on
    {1'b0,1'b1,1'b1,8'h00,8'h0F,1'b1,8'h00,8'h3C},  // R5 zeros
    {1'b0,1'b1,1'b1,8'h00,8'h0F,1'b0,8'h00,8'h3C},  // R5 delay on wake
    {1'b0,1'b1,1'b1,8'h00,8'h0F,1'b0,8'h03,8'h3C},  // R4 woke
    {1'b1,1'b0,1'b0,8'h00,8'h0F,1'b0,8'h00,8'h00},  // R7 idle, R1 clear
    {1'b0,1'b1,1'b1,8'h00,8'h0F,1'b0,8'h03,8'h00},  // R4 old level
    {1'b0,1'b1,1'b1,8'h00,8'h0F,1'b0,8'h0F,8'h00}   // R2 released
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R3 reset pulldn", pulldn_en, 8'h00);
    check("R3 reset rdata", bus_rdata, 8'h00);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      {bus_wr, bus_rd, bus_addr, bus_wdata, ext_lvl, sleep_en} = VEC[i][35:16];
      @(posedge clk);
      #1;
      check($sformatf("R6/R7 vector %0d rdata", i), bus_rdata, VEC[i][15:8]);
      check($sformatf("R1/R8 vector %0d pulldn", i), pulldn_en, VEC[i][7:0]);
    end

    // R4: pad changed during the low phase, read at next edge gives old level
    bus_wr = 1'b0; bus_rd = 1'b0;
    @(negedge clk);
    #0.5;
    ext_lvl = 8'hF0; bus_rd = 1'b1; bus_addr = 1'b1;
    @(posedge clk);
    #1;
    check("R4 same-edge old", bus_rdata, 8'h0F);
    @(posedge clk);
    #1;
    check("R4 next-edge new", bus_rdata, 8'hF0);

    // R3: reset raised in mid-cycle clears at once
    bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'hFF;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
    check("R1 all pulled", pulldn_en, 8'hFF);
    @(negedge clk);
    #0.5;
    rst = 1'b1;
    #0.5;
    check("R3 async clear", pulldn_en, 8'h00);
    @(posedge clk);
    #1;
    rst = 1'b0; bus_rd = 1'b1; bus_addr = 1'b0;
    @(posedge clk);
    #1;
    check("R3 reg cleared", bus_rdata, 8'h00);
    bus_rd = 1'b0;
    @(posedge clk);
    #1;
    check("R7 idle zero", bus_rdata, 8'h00);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule